// File: doc/BRIEF.md
# Event Ring Writer with Host Interrupt

This block is the device-side producer of a circular event ring kept in host memory. The device uses it to report completions and state changes. A client hands over one fixed-width event word with a valid/ready handshake. The block then issues a single write of that word to the ring slot named by its local read pointer and waits for the memory port to acknowledge it. After the acknowledge it moves the read pointer forward by one slot, wrapping at the ring size. It then raises a one-cycle interrupt to the host.

The host drains events at its own pace. It hands slots back by writing a new value into the block's local write pointer. The pointer roles are the reverse of a plain FIFO. The producer writes at the read pointer. The ring has no free slot when the two pointers are equal. The ring holds no pending events when the write pointer sits one slot behind the read pointer. When the ring is full, the block holds the client off through its ready signal, so no event is ever lost.

Top module: `evring_producer`

## Requirements
- R1: After reset, dev_rp is 0, dev_wp is DEPTH-1, ev_ready is 1, and both mem_req and irq_pulse are 0.
- R2: An event accepted on the rising edge where ev_valid and ev_ready are both 1 appears at the next cycle as mem_req=1, with mem_slot equal to the dev_rp value at acceptance and mem_word equal to the accepted word. All three hold unchanged, whatever ev_word does, until a cycle with mem_ack=1.
- R3: While dev_rp equals dev_wp, ev_ready is 0 and no write is issued. A waiting event is taken only after the host moves dev_wp away.
- R4: On the edge where mem_req and mem_ack are both 1, dev_rp advances by exactly one slot. At no other edge does dev_rp change.
- R5: irq_pulse is 1 for exactly one cycle, which is the cycle right after the acknowledged write. By that cycle dev_rp already shows the advanced value.
- R6: On the edge where host_wp_we is 1, dev_wp takes the value of host_wp. ev_ready is then recomputed from the new pointer pair in the following cycle.
- R7: From acceptance until the interrupt cycle has passed, ev_ready stays 0. Each accepted event therefore yields exactly one write and one interrupt.
- R8: dev_rp wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Client offers an event |
| ev_ready | output | 1 | Block can take an event this cycle |
| ev_word | input | WORD_W | Event descriptor word |
| mem_req | output | 1 | Descriptor write to host memory pending |
| mem_slot | output | IDX_W | Ring slot index of the write |
| mem_word | output | WORD_W | Descriptor word being written |
| mem_ack | input | 1 | Memory port accepts the pending write |
| host_wp_we | input | 1 | Host updates the write pointer |
| host_wp | input | IDX_W | New write pointer value from the host |
| irq_pulse | output | 1 | One-cycle interrupt to the host |
| dev_rp | output | IDX_W | Local read pointer (next slot to fill) |
| dev_wp | output | IDX_W | Local write pointer (host-returned limit) |

## Verification
A read pointer that is off by one would place the next descriptor in the wrong slot. That shows on mem_slot at the very next write, and it shows on dev_rp one cycle after the acknowledge. A broken full comparison shows in the first cycle the pointer pair reaches equality: either ev_ready rises when it should not, or it stays low after the host returns a slot. A sequencing fault, such as a pulse issued before the acknowledge, a pulse that lasts two cycles, or a write word taken from the live input, shows within the same event, in the cycle of the acknowledge or the cycle after it.

// File: rtl/evring_producer.sv
module evring_producer #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [WORD_W-1:0] ev_word,
  output logic              mem_req,
  output logic [IDX_W-1:0]  mem_slot,
  output logic [WORD_W-1:0] mem_word,
  input  logic              mem_ack,
  input  logic              host_wp_we,
  input  logic [IDX_W-1:0]  host_wp,
  output logic              irq_pulse,
  output logic [IDX_W-1:0]  dev_rp,
  output logic [IDX_W-1:0]  dev_wp
);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_NOTIFY} st_t;

  st_t              st;
  logic [IDX_W-1:0] rp_q, wp_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0] rp_inc;

  assign rp_inc    = (rp_q == IDX_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
  assign ev_ready  = (st == ST_IDLE) && (rp_q != wp_q);
  assign mem_req   = (st == ST_WRITE);
  assign mem_slot  = rp_q;
  assign mem_word  = word_q;
  assign irq_pulse = (st == ST_NOTIFY);
  assign dev_rp    = rp_q;
  assign dev_wp    = wp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rp_q   <= '0;
      wp_q   <= IDX_W'(DEPTH - 1);
      word_q <= '0;
    end else begin
      if (host_wp_we) wp_q <= host_wp;
      unique case (st)
        ST_IDLE: if (ev_valid && ev_ready) begin
          word_q <= ev_word;
          st     <= ST_WRITE;
        end
        ST_WRITE: if (mem_ack) begin
          rp_q <= rp_inc;
          st   <= ST_NOTIFY;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evring_producer_chk.sv
module evring_producer_chk #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              irq_pulse,
  input logic [IDX_W-1:0]  mem_slot,
  input logic [WORD_W-1:0] mem_word,
  input logic [IDX_W-1:0]  dev_rp,
  input logic [IDX_W-1:0]  dev_wp
);

  a_r3_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rp == dev_wp) |-> !ev_ready);

  a_r2_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_slot) && $stable(mem_word)));

  a_r4_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=>
      (dev_rp == (($past(dev_rp) == IDX_W'(DEPTH - 1)) ? IDX_W'(0) : IDX_W'($past(dev_rp) + 1'b1))));

  a_r4_rp_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack) |=> $stable(dev_rp));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r5_pulse_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(mem_req && mem_ack));

  a_r7_busy_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || irq_pulse) |-> !ev_ready);

endmodule

bind evring_producer evring_producer_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .mem_req(mem_req),
  .mem_ack(mem_ack), .irq_pulse(irq_pulse), .mem_slot(mem_slot),
  .mem_word(mem_word), .dev_rp(dev_rp), .dev_wp(dev_wp)
);

// File: tb/evring_producer_tb.sv
module evring_producer_tb_top;
  localparam int DEPTH  = 8;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, mem_ack = 0, host_wp_we = 0;
  logic [WORD_W-1:0] ev_word = '0;
  logic [IDX_W-1:0] host_wp = '0;
  logic ev_ready, mem_req, irq_pulse;
  logic [IDX_W-1:0] mem_slot, dev_rp, dev_wp;
  logic [WORD_W-1:0] mem_word;

  int n_chk = 0, n_bad = 0;
  int mrp, mwp;

  always #2 clk = ~clk;

  evring_producer #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_word(ev_word), .mem_req(mem_req), .mem_slot(mem_slot),
    .mem_word(mem_word), .mem_ack(mem_ack), .host_wp_we(host_wp_we),
    .host_wp(host_wp), .irq_pulse(irq_pulse), .dev_rp(dev_rp), .dev_wp(dev_wp)
  );

  // word[39:8], ack latency [7:4], slots returned by host [3:0]
  localparam logic [39:0] VEC [10] = '{
    {32'hA000_0001, 4'd0, 4'd0}, {32'hB000_0002, 4'd2, 4'd0},
    {32'hC000_0003, 4'd1, 4'd1}, {32'hD000_0004, 4'd0, 4'd2},
    {32'hE000_0005, 4'd3, 4'd0}, {32'h1234_5678, 4'd0, 4'd1},
    {32'hFFFF_FFFF, 4'd1, 4'd1}, {32'h0000_0000, 4'd0, 4'd2},
    {32'h5A5A_A5A5, 4'd2, 4'd1}, {32'hDEAD_BEEF, 4'd0, 4'd1}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ev_valid = 0; mem_ack = 0; host_wp_we = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
    mrp = 0; mwp = DEPTH - 1;
    chk(dev_rp == 0, "R1 rp", dev_rp, 0);
    chk(dev_wp == IDX_W'(DEPTH - 1), "R1 wp", dev_wp, DEPTH - 1);
    chk(ev_ready == 1, "R1 ready", ev_ready, 1);
    chk(mem_req == 0 && irq_pulse == 0, "R1 req/irq", {mem_req, irq_pulse}, 0);
  endtask

  // called at a negedge with ev_ready already 1 and ev_valid/ev_word set
  task automatic finish_event(input logic [WORD_W-1:0] w, input int lat);
    @(negedge clk);
    ev_valid = 0; ev_word = ~w;
    chk(mem_req == 1, "R2 req", mem_req, 1);
    chk(mem_slot == IDX_W'(mrp), "R2 slot", mem_slot, mrp);
    chk(mem_word == w, "R2 word", mem_word, w);
    chk(ev_ready == 0, "R7 busy", ev_ready, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_req == 1 && mem_word == w && dev_rp == IDX_W'(mrp), "R2 hold", mem_word, w);
      chk(irq_pulse == 0, "R5 early irq", irq_pulse, 0);
    end
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    mrp = nxt(mrp);
    chk(dev_rp == IDX_W'(mrp), "R4 rp step", dev_rp, mrp);
    chk(irq_pulse == 1, "R5 irq", irq_pulse, 1);
    chk(mem_req == 0 && ev_ready == 0, "R7 notify", {mem_req, ev_ready}, 0);
    @(negedge clk);
    chk(irq_pulse == 0, "R5 one cycle", irq_pulse, 0);
    chk(dev_rp == IDX_W'(mrp), "R4 rp still", dev_rp, mrp);
    chk(ev_ready == (mrp != mwp), "R3 ready", ev_ready, mrp != mwp);
  endtask

  task automatic post(input logic [WORD_W-1:0] w, input int lat);
    ev_valid = 1; ev_word = w;
    while (!ev_ready) @(negedge clk);
    finish_event(w, lat);
  endtask

  task automatic host_return(input int n);
    mwp = (mwp + n) % DEPTH;
    host_wp_we = 1; host_wp = IDX_W'(mwp);
    @(negedge clk);
    host_wp_we = 0;
    chk(dev_wp == IDX_W'(mwp), "R6 wp", dev_wp, mwp);
    chk(ev_ready == (mrp != mwp), "R6 ready", ev_ready, mrp != mwp);
  endtask

  initial begin
    do_reset();
    for (int v = 0; v < 10; v++) begin
      post(VEC[v][39:8], int'(VEC[v][7:4]));
      if (VEC[v][3:0] != 0) host_return(int'(VEC[v][3:0]));
    end
    chk(dev_rp == IDX_W'(2), "R8 wrap", dev_rp, 2);

    do_reset();
    for (int k = 0; k < DEPTH - 1; k++) post(32'h100 + k, 0);
    chk(ev_ready == 0, "R3 full", ev_ready, 0);
    ev_valid = 1; ev_word = 32'hCAFE_F00D;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(ev_ready == 0 && mem_req == 0, "R3 stall", {ev_ready, mem_req}, 0);
    end
    host_return(1);
    chk(ev_ready == 1, "R3 resume", ev_ready, 1);
    chk(mem_slot == IDX_W'(DEPTH - 1), "R8 last slot", mem_slot, DEPTH - 1);
    finish_event(32'hCAFE_F00D, 1);
    chk(dev_rp == 0, "R8 wrap to zero", dev_rp, 0);
    chk(ev_ready == 0, "R3 full again", ev_ready, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule